// File: doc/BRIEF.md
# Dual-Cluster Replicated Integer Register File

This block keeps two identical copies of an integer register file, each with 80 entries of 64 bits, one copy beside each of two execution clusters. Each cluster has an upper and a lower subcluster that produce results. A result is written straight into the copy of the cluster that produced it, so readers in that cluster see it one cycle later. A pipeline register carries the same result across to the other cluster's copy. Readers there see it one cycle after that. A load-data return port writes both copies in the same cycle.

Each copy has four combinational read ports, two per subcluster. A copy can take up to five writes on one clock edge: the two delayed results from the far cluster, the load return and the two local results. They are applied in a fixed order of age, so the younger write always wins. Writes issued in the same cycle follow one global ranking, and both copies apply it, so they end up with the same contents. Renaming, issue and the execution units sit outside the block.

Top module: `clusterRegFile`

## Requirements
- R1: After reset, every entry of both copies reads as zero on all eight read ports.
- R2: A write from write port w (w = 2*cluster + subcluster, with subcluster 1 the upper one) is returned by read ports 4*cluster to 4*cluster+3 in the cycle after it is presented. In the cycle it is presented, those ports still return the old value.
- R3: The same write is not seen by the other cluster's read ports in the cycle after it is presented. It is seen there two cycles after it is presented.
- R4: A load write is returned by all eight read ports in the cycle after it is presented, and not in the cycle it is presented.
- R5: When both subclusters of one cluster write the same entry in the same cycle, the upper subcluster's data wins in both copies.
- R6: Writes issued in the same cycle to the same entry rank by write port index, and the highest index wins. One cycle later each copy holds its own cluster's winner. Two cycles later both copies hold the global winner.
- R7: A load ranks below every subcluster write issued in the same cycle. Any write issued in a later cycle overrides a delayed write from the other cluster that lands on the same edge.
- R8: An address of 80 or above reads as zero, and a write or load to such an address changes no entry.
- R9: Each read port p (p = 4*cluster + 2*subcluster + k, k in 0..1) returns the entry at its own address, independently of the other seven ports in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 4 | Result write enables, index 2*cluster+subcluster |
| wrAddr | input | 4x7 | Result write addresses |
| wrData | input | 4x64 | Result write data |
| ldEn | input | 1 | Load return write enable, writes both copies |
| ldAddr | input | 7 | Load return address |
| ldData | input | 64 | Load return data |
| rdAddr | input | 8x7 | Read addresses, index 4*cluster+2*subcluster+k |
| rdData | output | 8x64 | Read data, combinational from rdAddr |

## Verification
The hardest situation to reach is two clusters writing the same entry in the same cycle. Right after that the two copies briefly disagree, and the far-cluster write that arrives late must then be dropped in one copy and applied in the other. The stimulus presents such pairs for several port combinations. It reads both copies one and two cycles later, and it also mixes in load returns and writes issued one cycle after a far-cluster write, so that an old delayed write lands on the same edge as a newer one.

// File: rtl/crfPkg.sv
`timescale 1ns/1ps
package crfPkg;
  localparam int CLUSTERS      = 2;
  localparam int SUBS          = 2;
  localparam int RD_PER_SUB    = 2;
  localparam int WR_PORTS      = CLUSTERS * SUBS;
  localparam int RD_PER_COPY   = SUBS * RD_PER_SUB;
  localparam int RD_PORTS      = CLUSTERS * RD_PER_COPY;
  // write slots of one copy, applied in ascending order (later slot wins)
  localparam int SLOT_RMT_BASE = 0;
  localparam int SLOT_LOAD     = SUBS;
  localparam int SLOT_LOC_BASE = SUBS + 1;
  localparam int SLOTS         = 2 * SUBS + 1;

  typedef struct packed {
    logic [SLOTS-1:0] wrStrobe;
  } slotStrobeT;
endpackage

// File: rtl/crfWriteCtrl.sv
`timescale 1ns/1ps
module crfWriteCtrl
  import crfPkg::*;
#(
  parameter int NUM_REGS    = 80,
  parameter int DATA_W      = 64,
  parameter int OWN_CLUSTER = 0,
  localparam int ADDR_W     = $clog2(NUM_REGS)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [SUBS-1:0]               locEn,
  input  logic [SUBS-1:0][ADDR_W-1:0]   locAddr,
  input  logic [SUBS-1:0][DATA_W-1:0]   locData,
  input  logic [SUBS-1:0]               rmtEn,
  input  logic [SUBS-1:0][ADDR_W-1:0]   rmtAddr,
  input  logic [SUBS-1:0][DATA_W-1:0]   rmtData,
  input  logic                          ldEn,
  input  logic [ADDR_W-1:0]             ldAddr,
  input  logic [DATA_W-1:0]             ldData,
  output slotStrobeT                    strobes,
  output logic [SLOTS-1:0][ADDR_W-1:0]  slotAddr,
  output logic [SLOTS-1:0][DATA_W-1:0]  slotData
);
  // same-cycle ranking follows the write port index, so the higher cluster outranks
  localparam bit LOCAL_OUTRANKS = (OWN_CLUSTER > (CLUSTERS - 1 - OWN_CLUSTER));
  localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(NUM_REGS);

  logic [SUBS-1:0]             dlyEn;
  logic [SUBS-1:0][ADDR_W-1:0] dlyAddr;
  logic [SUBS-1:0][DATA_W-1:0] dlyData;
  logic [SUBS-1:0]             prevEn;
  logic [SUBS-1:0][ADDR_W-1:0] prevAddr;
  logic [SUBS-1:0]             killRmt;

  function automatic logic inRange(input logic [ADDR_W-1:0] a);
    return {1'b0, a} < LIMIT;
  endfunction

  // far-cluster results wait one cycle; local issue of that cycle is remembered
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dlyEn    <= '0;
      dlyAddr  <= '0;
      dlyData  <= '0;
      prevEn   <= '0;
      prevAddr <= '0;
    end else begin
      dlyEn    <= rmtEn;
      dlyAddr  <= rmtAddr;
      dlyData  <= rmtData;
      prevEn   <= locEn;
      prevAddr <= locAddr;
    end
  end

  always_comb begin
    strobes = '0;
    killRmt = '0;
    for (int s = 0; s < SUBS; s++) begin
      for (int t = 0; t < SUBS; t++) begin
        if (prevEn[t] && prevAddr[t] == dlyAddr[s]) killRmt[s] = LOCAL_OUTRANKS;
      end
      strobes.wrStrobe[SLOT_RMT_BASE+s] = dlyEn[s] && !killRmt[s] && inRange(dlyAddr[s]);
      slotAddr[SLOT_RMT_BASE+s]         = dlyAddr[s];
      slotData[SLOT_RMT_BASE+s]         = dlyData[s];
      strobes.wrStrobe[SLOT_LOC_BASE+s] = locEn[s] && inRange(locAddr[s]);
      slotAddr[SLOT_LOC_BASE+s]         = locAddr[s];
      slotData[SLOT_LOC_BASE+s]         = locData[s];
    end
    strobes.wrStrobe[SLOT_LOAD] = ldEn && inRange(ldAddr);
    slotAddr[SLOT_LOAD]         = ldAddr;
    slotData[SLOT_LOAD]         = ldData;
  end
endmodule

// File: rtl/crfCopyBank.sv
`timescale 1ns/1ps
module crfCopyBank
  import crfPkg::*;
#(
  parameter int NUM_REGS = 80,
  parameter int DATA_W   = 64,
  localparam int ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  slotStrobeT                         strobes,
  input  logic [SLOTS-1:0][ADDR_W-1:0]       slotAddr,
  input  logic [SLOTS-1:0][DATA_W-1:0]       slotData,
  input  logic [RD_PER_COPY-1:0][ADDR_W-1:0] rdAddr,
  output logic [RD_PER_COPY-1:0][DATA_W-1:0] rdData
);
  localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(NUM_REGS);

  logic [DATA_W-1:0] mem [NUM_REGS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) mem[i] <= '0;
    end else begin
      for (int sl = 0; sl < SLOTS; sl++) begin
        if (strobes.wrStrobe[sl]) mem[slotAddr[sl]] <= slotData[sl];
      end
    end
  end

  for (genvar p = 0; p < RD_PER_COPY; p++) begin : g_rd
    assign rdData[p] = ({1'b0, rdAddr[p]} < LIMIT) ? mem[rdAddr[p]] : '0;
  end
endmodule

// File: rtl/clusterRegFile.sv
`timescale 1ns/1ps
module clusterRegFile
  import crfPkg::*;
#(
  parameter int NUM_REGS = 80,
  parameter int DATA_W   = 64,
  localparam int ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [WR_PORTS-1:0]             wrEn,
  input  logic [WR_PORTS-1:0][ADDR_W-1:0] wrAddr,
  input  logic [WR_PORTS-1:0][DATA_W-1:0] wrData,
  input  logic                            ldEn,
  input  logic [ADDR_W-1:0]               ldAddr,
  input  logic [DATA_W-1:0]               ldData,
  input  logic [RD_PORTS-1:0][ADDR_W-1:0] rdAddr,
  output logic [RD_PORTS-1:0][DATA_W-1:0] rdData
);
  for (genvar c = 0; c < CLUSTERS; c++) begin : g_copy
    localparam int FAR = CLUSTERS - 1 - c;
    slotStrobeT                   strobes;
    logic [SLOTS-1:0][ADDR_W-1:0] slotAddr;
    logic [SLOTS-1:0][DATA_W-1:0] slotData;

    crfWriteCtrl #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .OWN_CLUSTER(c)) u_ctrl (
      .clk     (clk),
      .rstN    (rstN),
      .locEn   (wrEn[c*SUBS +: SUBS]),
      .locAddr (wrAddr[c*SUBS +: SUBS]),
      .locData (wrData[c*SUBS +: SUBS]),
      .rmtEn   (wrEn[FAR*SUBS +: SUBS]),
      .rmtAddr (wrAddr[FAR*SUBS +: SUBS]),
      .rmtData (wrData[FAR*SUBS +: SUBS]),
      .ldEn    (ldEn),
      .ldAddr  (ldAddr),
      .ldData  (ldData),
      .strobes (strobes),
      .slotAddr(slotAddr),
      .slotData(slotData)
    );

    crfCopyBank #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_bank (
      .clk     (clk),
      .rstN    (rstN),
      .strobes (strobes),
      .slotAddr(slotAddr),
      .slotData(slotData),
      .rdAddr  (rdAddr[c*RD_PER_COPY +: RD_PER_COPY]),
      .rdData  (rdData[c*RD_PER_COPY +: RD_PER_COPY])
    );
  end
endmodule

// File: rtl/crfChecker.sv
`timescale 1ns/1ps
module crfChecker
  import crfPkg::*;
#(
  parameter int NUM_REGS = 80,
  parameter int DATA_W   = 64,
  localparam int ADDR_W  = $clog2(NUM_REGS)
) (
  input logic                            clk,
  input logic                            rstN,
  input logic [WR_PORTS-1:0]             wrEn,
  input logic [WR_PORTS-1:0][ADDR_W-1:0] wrAddr,
  input logic [WR_PORTS-1:0][DATA_W-1:0] wrData,
  input logic                            ldEn,
  input logic [ADDR_W-1:0]               ldAddr,
  input logic [DATA_W-1:0]               ldData,
  input logic [RD_PORTS-1:0][ADDR_W-1:0] rdAddr,
  input logic [RD_PORTS-1:0][DATA_W-1:0] rdData
);
  localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(NUM_REGS);

  logic [1:0] sinceRst;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  function automatic logic inRange(input logic [ADDR_W-1:0] a);
    return {1'b0, a} < LIMIT;
  endfunction

  // R2: cluster 0 upper result is the top-ranked write of its copy on its edge
  a_r2_local_next: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst != 2'd0 && $past(wrEn[1]) && inRange($past(wrAddr[1])) &&
     rdAddr[0] == $past(wrAddr[1]))
    |-> rdData[0] == $past(wrData[1]));

  // R3: cluster 1 upper result shows in copy 0 two cycles later unless newer writes hit
  a_r3_far_two: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 2'd2 && $past(wrEn[3], 2) && inRange($past(wrAddr[3], 2)) &&
     rdAddr[0] == $past(wrAddr[3], 2) &&
     !($past(wrEn[0]) && $past(wrAddr[0]) == rdAddr[0]) &&
     !($past(wrEn[1]) && $past(wrAddr[1]) == rdAddr[0]) &&
     !($past(ldEn) && $past(ldAddr) == rdAddr[0]))
    |-> rdData[0] == $past(wrData[3], 2));

  // R4: a load shows in copy 1 next cycle unless a cluster 1 result of that cycle hit it
  a_r4_load_next: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst != 2'd0 && $past(ldEn) && inRange($past(ldAddr)) &&
     rdAddr[4] == $past(ldAddr) &&
     !($past(wrEn[2]) && $past(wrAddr[2]) == rdAddr[4]) &&
     !($past(wrEn[3]) && $past(wrAddr[3]) == rdAddr[4]))
    |-> rdData[4] == $past(ldData));

  // R5: both cluster 0 subclusters to one entry, upper data wins
  a_r5_upper_wins: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst != 2'd0 && $past(wrEn[0]) && $past(wrEn[1]) &&
     $past(wrAddr[0]) == $past(wrAddr[1]) && inRange($past(wrAddr[1])) &&
     rdAddr[1] == $past(wrAddr[1]))
    |-> rdData[1] == $past(wrData[1]));

  // R8: out-of-range reads give zero on every port
  for (genvar p = 0; p < RD_PORTS; p++) begin : g_oob
    a_r8_oob_zero: assert property (@(posedge clk) disable iff (!rstN)
      !inRange(rdAddr[p]) |-> rdData[p] == '0);
  end
endmodule

bind clusterRegFile crfChecker #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_checker (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .ldEn(ldEn), .ldAddr(ldAddr), .ldData(ldData), .rdAddr(rdAddr), .rdData(rdData)
);

// File: tb/clusterRegFile_test.sv
`timescale 1ns/1ps
module clusterRegFile_test;
  localparam int NUM_REGS = 80;
  localparam int DATA_W   = 64;
  localparam int ADDR_W   = $clog2(NUM_REGS);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0]             wrEn;
  logic [3:0][ADDR_W-1:0] wrAddr;
  logic [3:0][DATA_W-1:0] wrData;
  logic                   ldEn;
  logic [ADDR_W-1:0]      ldAddr;
  logic [DATA_W-1:0]      ldData;
  logic [7:0][ADDR_W-1:0] rdAddr;
  logic [7:0][DATA_W-1:0] rdData;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int          qPort[$];
  logic [63:0] qVal[$];
  string       qTag[$];

  always #2.5 clk = ~clk;

  clusterRegFile uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .ldEn(ldEn), .ldAddr(ldAddr), .ldData(ldData), .rdAddr(rdAddr), .rdData(rdData)
  );

  function automatic logic [63:0] dval(input int w);
    return {32'hC0DE_0000, 32'(w + 1)};
  endfunction

  task automatic clearIn();
    wrEn = '0;
    ldEn = 1'b0;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    clearIn();
  endtask

  task automatic put(input int w, input int a, input logic [63:0] d);
    wrEn[w]   = 1'b1;
    wrAddr[w] = ADDR_W'(a);
    wrData[w] = d;
  endtask

  task automatic load(input int a, input logic [63:0] d);
    ldEn   = 1'b1;
    ldAddr = ADDR_W'(a);
    ldData = d;
  endtask

  // driver side of the scoreboard: set the read address, queue the expectation
  task automatic want(input int p, input int a, input logic [63:0] v, input string tag);
    rdAddr[p] = ADDR_W'(a);
    qPort.push_back(p);
    qVal.push_back(v);
    qTag.push_back(tag);
  endtask

  // monitor: mid-cycle, compare everything queued for this cycle
  int          mPort;
  logic [63:0] mVal;
  string       mTag;
  always @(negedge clk) begin
    while (qPort.size() > 0) begin
      mPort = qPort.pop_front();
      mVal  = qVal.pop_front();
      mTag  = qTag.pop_front();
      checks++;
      if (rdData[mPort] !== mVal) begin
        errors++;
        $display("FAIL %s port %0d actual %h expected %h", mTag, mPort, rdData[mPort], mVal);
      end
    end
  end

  // same-cycle cross-cluster pair, wa < wb in rank
  task automatic r6Pair(input int wa, input int wb, input int a);
    logic [63:0] x;
    logic [63:0] y;
    x = 64'hAAAA_0000_0000_0000 | 64'(a);
    y = 64'hBBBB_0000_0000_0000 | 64'(a);
    put(wa, a, x);
    put(wb, a, y);
    tick();
    want((wa / 2) * 4, a, x, "R6 own cluster first");
    want((wb / 2) * 4, a, y, "R6 own cluster first");
    tick();
    want(0, a, y, "R6 copies agree");
    want(4, a, y, "R6 copies agree");
    tick();
  endtask

  initial begin
    int lp;
    int rp;
    clearIn();
    wrAddr = '0;
    wrData = '0;
    ldAddr = '0;
    ldData = '0;
    rdAddr = '0;
    repeat (3) @(posedge clk);
    #1;
    rstN = 1'b1;

    // R1: reset contents
    for (int p = 0; p < 8; p++) want(p, p * 10 + 5, 64'd0, "R1 reset zero");
    tick();
    for (int p = 0; p < 8; p++) want(p, NUM_REGS - 1, 64'd0, "R1 reset zero top entry");
    tick();

    // R2 / R3: every producer against both clusters
    for (int w = 0; w < 4; w++) begin
      lp = (w / 2) * 4;
      rp = (1 - w / 2) * 4;
      put(w, 10 + w, dval(w));
      want(lp + (w % 2) * 2, 10 + w, 64'd0, "R2 old value same cycle");
      want(rp, 10 + w, 64'd0, "R3 old value same cycle");
      tick();
      for (int k = 0; k < 4; k++) want(lp + k, 10 + w, dval(w), "R2 local next cycle");
      want(rp, 10 + w, 64'd0, "R3 far copy not yet");
      tick();
      for (int k = 0; k < 4; k++) want(rp + k, 10 + w, dval(w), "R3 far copy after two");
      tick();
    end

    // R4: load to both copies
    load(20, 64'h1111_2222_3333_4444);
    want(0, 20, 64'd0, "R4 old value same cycle");
    want(4, 20, 64'd0, "R4 old value same cycle");
    tick();
    for (int p = 0; p < 8; p++) want(p, 20, 64'h1111_2222_3333_4444, "R4 load all ports");
    tick();

    // R5: upper beats lower inside a cluster
    put(2, 30, 64'h5555_0000_0000_0002);
    put(3, 30, 64'h5555_0000_0000_0003);
    tick();
    for (int k = 0; k < 4; k++) want(4 + k, 30, 64'h5555_0000_0000_0003, "R5 upper wins");
    tick();
    want(0, 30, 64'h5555_0000_0000_0003, "R5 upper wins far copy");
    tick();
    put(0, 31, 64'h6666_0000_0000_0000);
    put(1, 31, 64'h6666_0000_0000_0001);
    tick();
    want(1, 31, 64'h6666_0000_0000_0001, "R5 upper wins");
    tick();
    want(5, 31, 64'h6666_0000_0000_0001, "R5 upper wins far copy");
    tick();

    // R6: cross-cluster same-cycle conflicts
    r6Pair(1, 3, 40);
    r6Pair(0, 2, 41);
    r6Pair(1, 2, 42);
    r6Pair(0, 3, 43);

    // R7: load loses to same-cycle result
    load(50, 64'h7777_0000_0000_00AA);
    put(0, 50, 64'h7777_0000_0000_00DD);
    tick();
    want(0, 50, 64'h7777_0000_0000_00DD, "R7 load loses in own copy");
    want(4, 50, 64'h7777_0000_0000_00AA, "R7 load before far result");
    tick();
    want(0, 50, 64'h7777_0000_0000_00DD, "R7 result kept");
    want(4, 50, 64'h7777_0000_0000_00DD, "R7 far result over load");
    tick();

    // R7: newer local write beats older far write landing on the same edge
    put(2, 51, 64'h8888_0000_0000_000F);
    tick();
    put(0, 51, 64'h8888_0000_0000_0001);
    want(0, 51, 64'd0, "R3 far copy not yet");
    tick();
    want(0, 51, 64'h8888_0000_0000_0001, "R7 newer local wins");
    want(4, 51, 64'h8888_0000_0000_000F, "R7 far copy still older");
    tick();
    want(0, 51, 64'h8888_0000_0000_0001, "R7 newer local kept");
    want(4, 51, 64'h8888_0000_0000_0001, "R7 newer reaches far copy");
    tick();

    // R7: load issued after a far write overrides it
    put(2, 52, 64'h9999_0000_0000_0002);
    tick();
    load(52, 64'h9999_0000_0000_00BB);
    tick();
    want(0, 52, 64'h9999_0000_0000_00BB, "R7 later load wins");
    want(4, 52, 64'h9999_0000_0000_00BB, "R7 later load wins");
    tick();

    // R8: out-of-range addresses
    put(0, 100, 64'hDEAD_BEEF_0000_0001);
    put(3, 116, 64'hDEAD_BEEF_0000_0003);
    load(127, 64'hDEAD_BEEF_0000_0007);
    want(0, 100, 64'd0, "R8 oob read zero");
    tick();
    want(0, 100, 64'd0, "R8 oob write ignored");
    want(1, 20, 64'h1111_2222_3333_4444, "R8 no alias");
    want(2, 36, 64'd0, "R8 no alias");
    want(3, 47, 64'd0, "R8 no alias");
    want(4, 127, 64'd0, "R8 oob write ignored");
    want(5, 36, 64'd0, "R8 no alias");
    tick();
    want(6, 20, 64'h1111_2222_3333_4444, "R8 no alias far copy");
    want(7, 63, 64'd0, "R8 no alias far copy");
    want(0, 116, 64'd0, "R8 oob far write ignored");
    tick();

    // R9: eight independent addresses in one cycle
    want(0, 10, dval(0), "R9 port independence");
    want(1, 11, dval(1), "R9 port independence");
    want(2, 12, dval(2), "R9 port independence");
    want(3, 13, dval(3), "R9 port independence");
    want(4, 30, 64'h5555_0000_0000_0003, "R9 port independence");
    want(5, 20, 64'h1111_2222_3333_4444, "R9 port independence");
    want(6, 51, 64'h8888_0000_0000_0001, "R9 port independence");
    want(7, 79, 64'd0, "R9 port independence");
    tick();
    tick();

    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired before the sequence ended");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule